// File: doc/BRIEF.md
# Accumulator Multicycle Processor Core

A compact single-accumulator processor core for control tasks. Instructions and data share one 18-bit word-addressable memory reached through a synchronous port, and each instruction passes through a multicycle control sequence: fetch, decode, an optional pointer read, execute and a result cycle. Memory-reference instructions name an operand through one of four address modes. Two of these modes add one of two 13-bit index registers. All remaining operations sit in one operand-less group that is selected by a sub-operation field.

The core talks to a memory that returns read data one clock after the request. It also has an 18-bit input word and an 18-bit output word, and data reaches or leaves either one only through the accumulator. Once it executes HALT, the core stops making memory accesses and holds `halted` high until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is asserted, `halted`, `io_out_valid` and `io_out` are 0. In the first cycle after reset is released, the core requests a read (`mem_re`=1, `mem_we`=0) at address 0. PC, AC, CF and both index registers reset to 0.
- R2: Each instruction word is laid out as opcode [17:15], mode [14:13] and address field [12:0]. Opcode 000 loads AC from the operand and opcode 001 stores AC to the operand address.
- R3: The mode field selects the effective address: 00 uses the field itself, 01 reads the word at the field and takes its bits [12:0] (costing one extra cycle), 10 gives field+IA modulo 8192, and 11 gives field+IB modulo 8192.
- R4: Opcode 010 adds the operand to AC and opcode 011 subtracts it, both in two's complement. After an add, CF holds the carry out. After a subtract, CF holds the borrow, which is 1 exactly when AC < operand as unsigned numbers. Opcode 100 ANDs the operand into AC. No operation other than add and subtract changes CF.
- R5: Opcode 101 jumps to the effective address. Opcode 110 writes the incremented PC to the effective address and continues at the effective address + 1. The group operation RET continues at the word stored at the effective address of the most recent subroutine call.
- R6: Opcode 111 is the operand-less group, with the sub-operation in bits [12:9] and a 9-bit immediate in bits [8:0]. The codes are 0 HALT, 1 NOT (AC inverted), 2 OR-immediate (AC ORed with the zero-extended immediate), 3 RET, 9 copy AC[12:0] into IA, and 10 copy AC[12:0] into IB.
- R7: Group codes 4, 5 and 6 branch when AC is zero, when AC[17] is 1, and when CF is 1, respectively. A taken branch goes to the incremented PC plus the sign-extended immediate, modulo 8192; otherwise execution falls through. Backward offsets are allowed.
- R8: Group code 7 loads AC from `io_in`. Group code 8 copies AC to `io_out` and raises `io_out_valid` for exactly one cycle.
- R9: After HALT, `mem_re` and `mem_we` stay 0 and `halted` stays 1 until reset.
- R10: Read data is used one cycle after `mem_re`. Load, add, subtract, AND and RET take 4 cycles. Store, jumps, call and the other group operations take 3 cycles. Indirect mode adds 1 cycle.
- R11: Group codes 11 to 15 change no register and make no memory access other than the instruction fetch.
- R12: `mem_re` and `mem_we` are never high in the same cycle, and a store writes the value of AC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 13 | Memory word address |
| mem_re | output | 1 | Read request; data is returned the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 18 | Write data |
| mem_rdata | input | 18 | Read data from the previous cycle's request |
| io_in | input | 18 | Input word read by IN |
| io_out | output | 18 | Output word written by OUT |
| io_out_valid | output | 1 | One-cycle pulse when `io_out` is updated |
| halted | output | 1 | High once HALT has executed |

## Verification
Every result in this core is due a fixed number of edges after its stimulus. Read data is returned on the edge after `mem_re`. A value from OUT appears on `io_out` together with a one-cycle `io_out_valid` on the edge after that instruction's execute cycle, and `halted` rises on the third edge of a HALT. The bench drives inputs on falling edges and samples one time unit after rising edges. It collects output words only on edges where `io_out_valid` was high, and it counts edges from reset release to `halted` for a program whose per-instruction cycle costs add up to 15. Arithmetic results and carry/borrow values are computed in the bench from wide sums over a sweep of boundary operands.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
   localparam int OP_W  = 3;
   localparam int MD_W  = 2;
   localparam int SUB_W = 4;

   localparam logic [OP_W-1:0] OP_LDA = 3'b000;
   localparam logic [OP_W-1:0] OP_STA = 3'b001;
   localparam logic [OP_W-1:0] OP_ADD = 3'b010;
   localparam logic [OP_W-1:0] OP_SUB = 3'b011;
   localparam logic [OP_W-1:0] OP_AND = 3'b100;
   localparam logic [OP_W-1:0] OP_JMP = 3'b101;
   localparam logic [OP_W-1:0] OP_JSR = 3'b110;
   localparam logic [OP_W-1:0] OP_GRP = 3'b111;

   localparam logic [MD_W-1:0] MD_DIR = 2'b00;
   localparam logic [MD_W-1:0] MD_IND = 2'b01;
   localparam logic [MD_W-1:0] MD_IXA = 2'b10;
   localparam logic [MD_W-1:0] MD_IXB = 2'b11;

   localparam logic [SUB_W-1:0] G_HALT = 4'd0;
   localparam logic [SUB_W-1:0] G_NOT  = 4'd1;
   localparam logic [SUB_W-1:0] G_ORI  = 4'd2;
   localparam logic [SUB_W-1:0] G_RET  = 4'd3;
   localparam logic [SUB_W-1:0] G_JZ   = 4'd4;
   localparam logic [SUB_W-1:0] G_JN   = 4'd5;
   localparam logic [SUB_W-1:0] G_JC   = 4'd6;
   localparam logic [SUB_W-1:0] G_IN   = 4'd7;
   localparam logic [SUB_W-1:0] G_OUT  = 4'd8;
   localparam logic [SUB_W-1:0] G_TIA  = 4'd9;
   localparam logic [SUB_W-1:0] G_TIB  = 4'd10;

   typedef enum logic [2:0] {
      S_FETCH, S_DECODE, S_INDIRECT, S_EXECUTE, S_WRITEBACK, S_HALT
   } state_t;

   typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND} alu_op_t;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int W            = 18,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  alu_op_t        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y,
   output logic           cout,
   output logic           flag_we
);
   logic [W-1:0] arith_y;
   logic         arith_c;

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder: subtract as a + ~b + 1, borrow is the inverted carry
         logic         do_sub;
         logic [W:0]   sum;
         assign do_sub  = (op == ALU_SUB);
         assign sum     = {1'b0, a} + {1'b0, (do_sub ? ~b : b)} + {{W{1'b0}}, do_sub};
         assign arith_y = sum[W-1:0];
         assign arith_c = do_sub ? ~sum[W] : sum[W];
      end else begin : g_split
         logic [W:0] s_add;
         logic [W:0] s_sub;
         assign s_add   = {1'b0, a} + {1'b0, b};
         assign s_sub   = {1'b0, a} - {1'b0, b};
         assign arith_y = (op == ALU_SUB) ? s_sub[W-1:0] : s_add[W-1:0];
         assign arith_c = (op == ALU_SUB) ? s_sub[W]     : s_add[W];
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_ADD, ALU_SUB: y = arith_y;
         ALU_AND:          y = a & b;
         default:          y = b;
      endcase
      cout    = arith_c;
      flag_we = (op == ALU_ADD) || (op == ALU_SUB);
   end
endmodule

// File: rtl/acc_cpu_ea.sv
module acc_cpu_ea
   import acc_cpu_pkg::*;
#(
   parameter int AW = 13
)(
   input  logic [MD_W-1:0] mode,
   input  logic [AW-1:0]   field,
   input  logic [AW-1:0]   ia,
   input  logic [AW-1:0]   ib,
   output logic [AW-1:0]   ea
);
   // indirect mode passes the pointer address; the core fetches through it
   always_comb begin
      case (mode)
         MD_IXA:  ea = field + ia;
         MD_IXB:  ea = field + ib;
         default: ea = field;
      endcase
   end
endmodule

// File: rtl/acc_cpu_idx.sv
module acc_cpu_idx #(
   parameter int AW   = 13,
   parameter int NIDX = 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NIDX-1:0]          we,
   input  logic [AW-1:0]            din,
   output logic [NIDX-1:0][AW-1:0]  q
);
   for (genvar k = 0; k < NIDX; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[k] <= '0;
         else if (we[k]) q[k] <= din;
      end

      // R6: an index register changes only on its own copy operation
      assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !we[k] |=> (q[k] == $past(q[k])));
   end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int W            = 18,
   parameter int AW           = 13,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] mem_addr,
   output logic          mem_re,
   output logic          mem_we,
   output logic [W-1:0]  mem_wdata,
   input  logic [W-1:0]  mem_rdata,
   input  logic [W-1:0]  io_in,
   output logic [W-1:0]  io_out,
   output logic          io_out_valid,
   output logic          halted
);
   localparam int NIDX  = 2;
   localparam int IMM_W = AW - SUB_W;
   localparam logic [AW-1:0] A_ONE = AW'(1);

   initial begin
      assert (W == OP_W + MD_W + AW) else $error("word width must be opcode+mode+address");
      assert (IMM_W >= 2) else $error("address field too narrow for group immediate");
      assert (W > AW) else $error("word must be wider than an address");
   end

   state_t            state;
   logic [OP_W-1:0]   ir_op;
   logic [AW-1:0]     ir_arg;
   logic [W-1:0]      ac;
   logic              cf;
   logic [AW-1:0]     pc, ma, lr;

   // fields of the word arriving during decode
   logic [OP_W-1:0]   d_op;
   logic [MD_W-1:0]   d_mode;
   logic [AW-1:0]     d_field, d_ea;
   assign d_op    = mem_rdata[W-1 -: OP_W];
   assign d_mode  = mem_rdata[AW +: MD_W];
   assign d_field = mem_rdata[AW-1:0];

   // group fields of the held instruction
   logic [SUB_W-1:0]  g_sub;
   logic [IMM_W-1:0]  g_imm;
   logic [AW-1:0]     rel_target;
   logic              take;
   assign g_sub      = ir_arg[AW-1 -: SUB_W];
   assign g_imm      = ir_arg[IMM_W-1:0];
   assign rel_target = pc + {{(AW-IMM_W){g_imm[IMM_W-1]}}, g_imm};

   logic [NIDX-1:0]          idx_we;
   logic [NIDX-1:0][AW-1:0]  idx_q;

   alu_op_t           alu_op;
   logic [W-1:0]      alu_y;
   logic              alu_c, alu_fwe;

   acc_cpu_ea #(.AW(AW)) u_ea (
      .mode(d_mode), .field(d_field), .ia(idx_q[0]), .ib(idx_q[1]), .ea(d_ea));

   acc_cpu_idx #(.AW(AW), .NIDX(NIDX)) u_idx (
      .clk(clk), .rst_n(rst_n), .we(idx_we), .din(ac[AW-1:0]), .q(idx_q));

   acc_cpu_alu #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op(alu_op), .a(ac), .b(mem_rdata), .y(alu_y), .cout(alu_c), .flag_we(alu_fwe));

   always_comb begin
      case (ir_op)
         OP_ADD:  alu_op = ALU_ADD;
         OP_SUB:  alu_op = ALU_SUB;
         OP_AND:  alu_op = ALU_AND;
         default: alu_op = ALU_PASS;
      endcase
      case (g_sub)
         G_JZ:    take = (ac == '0);
         G_JN:    take = ac[W-1];
         G_JC:    take = cf;
         default: take = 1'b0;
      endcase
      idx_we[0] = (state == S_EXECUTE) && (ir_op == OP_GRP) && (g_sub == G_TIA);
      idx_we[1] = (state == S_EXECUTE) && (ir_op == OP_GRP) && (g_sub == G_TIB);
   end

   // memory port steering
   always_comb begin
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = pc;
      mem_wdata = ac;
      case (state)
         S_FETCH: mem_re = 1'b1;
         S_DECODE: begin
            if (d_op != OP_GRP && d_mode == MD_IND) begin
               mem_re   = 1'b1;
               mem_addr = d_field;
            end
         end
         S_EXECUTE: begin
            case (ir_op)
               OP_LDA, OP_ADD, OP_SUB, OP_AND: begin
                  mem_re   = 1'b1;
                  mem_addr = ma;
               end
               OP_STA: begin
                  mem_we   = 1'b1;
                  mem_addr = ma;
               end
               OP_JSR: begin
                  mem_we    = 1'b1;
                  mem_addr  = ma;
                  mem_wdata = {{(W-AW){1'b0}}, pc};
               end
               OP_GRP: begin
                  if (g_sub == G_RET) begin
                     mem_re   = 1'b1;
                     mem_addr = lr;
                  end
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_FETCH;
         pc           <= '0;
         ac           <= '0;
         cf           <= 1'b0;
         ma           <= '0;
         lr           <= '0;
         ir_op        <= OP_LDA;
         ir_arg       <= '0;
         io_out       <= '0;
         io_out_valid <= 1'b0;
      end else begin
         io_out_valid <= 1'b0;
         case (state)
            S_FETCH: state <= S_DECODE;
            S_DECODE: begin
               ir_op  <= d_op;
               ir_arg <= d_field;
               pc     <= pc + A_ONE;
               ma     <= d_ea;
               if (d_op != OP_GRP && d_mode == MD_IND) state <= S_INDIRECT;
               else                                    state <= S_EXECUTE;
            end
            S_INDIRECT: begin
               ma    <= mem_rdata[AW-1:0];
               state <= S_EXECUTE;
            end
            S_EXECUTE: begin
               state <= S_FETCH;
               case (ir_op)
                  OP_LDA, OP_ADD, OP_SUB, OP_AND: state <= S_WRITEBACK;
                  OP_JMP: pc <= ma;
                  OP_JSR: begin
                     pc <= ma + A_ONE;
                     lr <= ma;
                  end
                  OP_GRP: begin
                     case (g_sub)
                        G_HALT: state <= S_HALT;
                        G_NOT:  ac <= ~ac;
                        G_ORI:  ac <= ac | {{(W-IMM_W){1'b0}}, g_imm};
                        G_RET:  state <= S_WRITEBACK;
                        G_JZ, G_JN, G_JC: if (take) pc <= rel_target;
                        G_IN:   ac <= io_in;
                        G_OUT: begin
                           io_out       <= ac;
                           io_out_valid <= 1'b1;
                        end
                        default: ;
                     endcase
                  end
                  default: ;
               endcase
            end
            S_WRITEBACK: begin
               state <= S_FETCH;
               if (ir_op == OP_GRP) pc <= mem_rdata[AW-1:0];
               else begin
                  ac <= alu_y;
                  if (alu_fwe) cf <= alu_c;
               end
            end
            S_HALT:  state <= S_HALT;
            default: state <= S_FETCH;
         endcase
      end
   end

   assign halted = (state == S_HALT);

   assert_no_rw_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   assert_write_only_in_execute_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (state == S_EXECUTE));

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_re && !mem_we));

   assert_out_copies_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      io_out_valid |-> (io_out == ac));

   assert_out_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      io_out_valid |=> !io_out_valid);

   assert_fetch_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DECODE) |=> (pc == $past(pc) + A_ONE));

   assert_indirect_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_INDIRECT) |=> (state == S_EXECUTE));
endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 18;
   localparam int AW   = 13;
   localparam int MEMW = 1024;

   localparam int LDA = 0, STA = 1, ADD = 2, SUB = 3, AND = 4, JMP = 5, JSR = 6;
   localparam int DIR = 0, IND = 1, IXA = 2, IXB = 3;
   localparam int HLT = 0, NOTX = 1, ORI = 2, RET = 3, JZ = 4, JN = 5, JC = 6;
   localparam int INP = 7, OUTP = 8, TIA = 9, TIB = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_re, mem_we;
   logic [W-1:0]  mem_wdata;
   logic [W-1:0]  mem_rdata = '0;
   logic [W-1:0]  io_in = '0;
   logic [W-1:0]  io_out;
   logic          io_out_valid, halted;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu_core u0 (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_in(io_in), .io_out(io_out),
      .io_out_valid(io_out_valid), .halted(halted));

   logic [W-1:0] mem [MEMW];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
   end

   logic [W-1:0] outs [16];
   int n_out = 0;
   always @(posedge clk) begin
      if (!rst_n) n_out <= 0;
      else if (io_out_valid) begin
         if (n_out < 16) outs[n_out] <= io_out;
         n_out <= n_out + 1;
      end
   end

   int clash = 0;
   always @(posedge clk) if (rst_n && mem_re && mem_we) clash <= clash + 1;

   int n_chk = 0, n_fail = 0, tot = 0;

   always @(posedge clk) begin
      tot <= tot + 1;
      if (tot == 190000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=<190000", tot);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mi(input int op, input int md, input int a);
      return {3'(op), 2'(md), 13'(a)};
   endfunction

   function automatic logic [W-1:0] gi(input int sub, input int imm);
      return {3'b111, 2'b00, 4'(sub), 9'(imm)};
   endfunction

   task automatic clear_mem;
      for (int i = 0; i < MEMW; i++) mem[i] = '0;
   endtask

   task automatic run_prog(output int cyc);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted && cyc < 3000) begin
         @(posedge clk); #1;
         cyc++;
      end
      check(halted == 1'b1, "R9 program reaches halt", cyc, 0);
   endtask

   logic [W-1:0] vals [8];
   initial begin
      int cyc;
      logic [W:0] wide;
      logic [W-1:0] a, b, er;
      logic ec;
      vals[0] = 18'h00000; vals[1] = 18'h00001; vals[2] = 18'h00002; vals[3] = 18'h1FFFF;
      vals[4] = 18'h20000; vals[5] = 18'h3FFFF; vals[6] = 18'h15555; vals[7] = 18'h2AAAA;

      // R1 reset state and first fetch
      clear_mem();
      mem[0] = gi(HLT, 0);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(!halted && !io_out_valid && io_out == '0, "R1 outputs in reset",
            {halted, io_out_valid, io_out}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(mem_re && !mem_we && mem_addr == '0, "R1 first fetch at 0",
            {mem_re, mem_we, mem_addr}, {2'b10, 13'd0});

      // R4 arithmetic and AND sweep, carry reported through JC (R7)
      for (int op = ADD; op <= AND; op++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               a = vals[i]; b = vals[j];
               clear_mem();
               mem[0] = mi(LDA, DIR, 100);
               mem[1] = mi(op, DIR, 101);
               mem[2] = gi(OUTP, 0);
               mem[3] = mi(LDA, DIR, 102);
               mem[4] = gi(JC, 2);
               mem[5] = gi(OUTP, 0);
               mem[6] = gi(HLT, 0);
               mem[7] = gi(ORI, 1);
               mem[8] = gi(OUTP, 0);
               mem[9] = gi(HLT, 0);
               mem[100] = a; mem[101] = b; mem[102] = '0;
               if (op == ADD) begin
                  wide = {1'b0, a} + {1'b0, b};
                  er = wide[W-1:0]; ec = wide[W];
               end else if (op == SUB) begin
                  wide = {1'b0, a} - {1'b0, b};
                  er = wide[W-1:0]; ec = (a < b);
               end else begin
                  er = a & b; ec = 1'b0;
               end
               run_prog(cyc);
               check(n_out == 2, "R4 output count", n_out, 2);
               check(outs[0] == er, "R4 result", outs[0], er);
               check(outs[1] == {17'd0, ec}, "R4 carry/borrow via R7 JC", outs[1], ec);
            end
         end
      end

      // R3 addressing modes, R6 index copies, R12 store data
      clear_mem();
      mem[0]  = mi(LDA, DIR, 100);
      mem[1]  = gi(TIA, 0);
      mem[2]  = mi(LDA, DIR, 101);
      mem[3]  = gi(TIB, 0);
      mem[4]  = mi(LDA, IXA, 300);
      mem[5]  = gi(OUTP, 0);
      mem[6]  = mi(LDA, IXB, 310);
      mem[7]  = gi(OUTP, 0);
      mem[8]  = mi(LDA, IND, 102);
      mem[9]  = gi(OUTP, 0);
      mem[10] = mi(STA, IXA, 500);
      mem[11] = mi(STA, IND, 103);
      mem[12] = gi(HLT, 0);
      mem[100] = 18'd5; mem[101] = 18'd8191;
      mem[102] = {5'h1F, 13'd400}; mem[103] = 18'd410;
      mem[305] = 18'h11111; mem[309] = 18'h22222; mem[400] = 18'h33333;
      run_prog(cyc);
      check(outs[0] == 18'h11111, "R3 indexed by IA", outs[0], 18'h11111);
      check(outs[1] == 18'h22222, "R3 indexed by IB wraps mod 8192", outs[1], 18'h22222);
      check(outs[2] == 18'h33333, "R3 indirect low 13 bits", outs[2], 18'h33333);
      check(mem[505] == 18'h33333, "R2 R12 indexed store", mem[505], 18'h33333);
      check(mem[410] == 18'h33333, "R2 R12 indirect store", mem[410], 18'h33333);

      // R10 cycle count: 4 + 5 + 3 + 3 edges
      clear_mem();
      mem[0] = mi(LDA, DIR, 100);
      mem[1] = mi(LDA, IND, 102);
      mem[2] = mi(STA, DIR, 120);
      mem[3] = gi(HLT, 0);
      mem[100] = 18'd7; mem[102] = 18'd101; mem[101] = 18'h0ABCD;
      run_prog(cyc);
      check(cyc == 15, "R10 instruction cycle totals", cyc, 15);
      check(mem[120] == 18'h0ABCD, "R2 load then store", mem[120], 18'h0ABCD);

      // R5 call, return, jump; R6 NOT and OR-immediate
      clear_mem();
      mem[0]  = mi(LDA, DIR, 100);
      mem[1]  = mi(JSR, DIR, 50);
      mem[2]  = gi(OUTP, 0);
      mem[3]  = mi(JMP, DIR, 60);
      mem[4]  = gi(HLT, 0);
      mem[51] = gi(ORI, 8);
      mem[52] = gi(RET, 0);
      mem[60] = gi(NOTX, 0);
      mem[61] = gi(OUTP, 0);
      mem[62] = gi(HLT, 0);
      mem[100] = 18'd7;
      run_prog(cyc);
      check(mem[50] == 18'd2, "R5 call stores return address", mem[50], 2);
      check(outs[0] == 18'd15, "R5 R6 subroutine ORI and return", outs[0], 15);
      check(outs[1] == 18'h3FFF0, "R5 R6 jump then NOT", outs[1], 18'h3FFF0);
      check(n_out == 2, "R5 output count", n_out, 2);

      // R7 zero branch taken and not taken
      clear_mem();
      mem[0] = mi(LDA, DIR, 100);
      mem[1] = gi(JZ, 1);
      mem[2] = gi(OUTP, 0);
      mem[3] = gi(ORI, 5);
      mem[4] = gi(OUTP, 0);
      mem[5] = mi(LDA, DIR, 101);
      mem[6] = gi(JZ, 1);
      mem[7] = gi(OUTP, 0);
      mem[8] = gi(HLT, 0);
      mem[100] = 18'd0; mem[101] = 18'd7;
      run_prog(cyc);
      check(n_out == 2, "R7 zero branch output count", n_out, 2);
      check(outs[0] == 18'd5, "R7 zero branch taken", outs[0], 5);
      check(outs[1] == 18'd7, "R7 zero branch not taken", outs[1], 7);

      // R7 negative branch with backward offset
      clear_mem();
      mem[0] = mi(LDA, DIR, 100);
      mem[1] = mi(ADD, DIR, 101);
      mem[2] = gi(OUTP, 0);
      mem[3] = gi(JN, -3);
      mem[4] = gi(HLT, 0);
      mem[100] = 18'h3FFFD; mem[101] = 18'd1;
      run_prog(cyc);
      check(n_out == 3, "R7 backward loop iterations", n_out, 3);
      check(outs[0] == 18'h3FFFE && outs[1] == 18'h3FFFF && outs[2] == 18'd0,
            "R7 backward loop values", outs[2], 0);

      // R8 input/output, R11 unassigned codes leave state alone
      clear_mem();
      io_in = 18'h2BCDE;
      mem[0] = gi(INP, 0);
      mem[1] = gi(OUTP, 0);
      mem[2] = gi(15, 0);
      mem[3] = gi(11, 3);
      mem[4] = gi(OUTP, 0);
      mem[5] = gi(HLT, 0);
      run_prog(cyc);
      check(outs[0] == 18'h2BCDE, "R8 IN then OUT", outs[0], 18'h2BCDE);
      check(outs[1] == 18'h2BCDE, "R11 unassigned codes keep AC", outs[1], 18'h2BCDE);
      check(n_out == 2, "R8 one pulse per OUT", n_out, 2);
      check(mem[0] == gi(INP, 0) && mem[3] == gi(11, 3), "R11 no memory write", mem[3], gi(11, 3));

      // R9 halted core stays quiet
      begin
         int busy = 0;
         for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            if (mem_re || mem_we || !halted) busy++;
         end
         check(busy == 0, "R9 no access after halt", busy, 0);
      end

      check(clash == 0, "R12 read and write never together", clash, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule